// File: doc/BRIEF.md
# Fault Event Latch with Service-Request Message

This block watches an 8-bit vector of live fault conditions from a power stage. Each condition bit has a matching bit in an enable mask. When a masked-in condition bit changes in either direction, the block reacts in two ways. A rising edge sets the matching bit in a sticky event register. Any change, rising or falling, starts a short ASCII service-request message to the host. The message is a `!`, then the unit's bus address as two decimal digits, then a carriage return. It goes out one byte at a time on a valid/ready byte stream, which a UART or command layer consumes.

Firmware or a command decoder sits in front of the block. It writes the enable mask and pulses a read-and-clear strobe when the host reads the event register. It also pulses a clear-status input and a reset-command input. A power-up input acts as the hardware reset. Changes that arrive while a message is still being sent collapse into a single pending flag, so exactly one follow-up message is sent.

The message sequencer is an FSM with five states:
- `ST_IDLE`: no output.
- `ST_BANG`: sends `!`.
- `ST_TENS`: sends the tens digit.
- `ST_ONES`: sends the ones digit.
- `ST_CR`: sends the carriage return.

Its transitions are:
- start (`ST_IDLE` to `ST_BANG`, on a change or a pending flag);
- advance (`ST_BANG` to `ST_TENS` to `ST_ONES` to `ST_CR`, each on an accepted byte);
- finish (`ST_CR` to `ST_IDLE`, on acceptance with nothing waiting);
- chain (`ST_CR` to `ST_BANG`, on acceptance with a change or pending flag);
- abort (any state to `ST_IDLE`, on reset command or power-up).

Top module: `fault_srq_latch`

## Requirements
- R1: Condition bit positions are fixed: bit 0 spare, bit 1 AC fail, bit 2 over-temperature, bit 3 foldback, bit 4 over-voltage, bit 5 shut-off, bit 6 output off, bit 7 enable. An event bit is set on the clock edge where its condition goes from 0 to 1 relative to the previous cycle, and only if its enable bit is 1.
- R2: An event bit stays set after its condition returns to 0. Without a read, clear-status or power-up it never clears.
- R3: A read-and-clear strobe clears the whole event register at the next edge. If a new enabled rising edge occurs in the same cycle, that edge's bit reads as set after the clear.
- R4: A clear-status pulse clears the whole event register at the next edge.
- R5: A reset-command pulse leaves the event register unchanged. It clears the enable mask to 0x00 and abandons any message in progress, so the byte output is invalid in the next cycle.
- R6: While power-up is low, the event register, the enable mask, the pending flag and the sequencer all return to idle or zero. Conditions present when power-up is released form the baseline and produce no event and no message.
- R7: A mask write takes effect from the next cycle. With a mask of 0x00, no condition change produces a message or an event.
- R8: A rising or falling change on any enabled bit starts a message of 0x21, the ASCII tens digit, the ASCII ones digit, then 0x0D. The address is latched when the message starts. An address above 99 is sent as 99.
- R9: Each byte is held on the output, with valid high and the data stable, until valid and ready are both high at a clock edge.
- R10: Any number of enabled changes during a message leads to exactly one more complete message after it. The output then goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up, active low, synchronous |
| cond_i | input | 8 | Live fault condition vector |
| ena_wr_i | input | 1 | Enable-mask write strobe |
| ena_data_i | input | 8 | Enable-mask write value |
| evt_rd_i | input | 1 | Event register read-and-clear strobe |
| cls_i | input | 1 | Clear-status pulse |
| rst_cmd_i | input | 1 | Reset-command pulse |
| addr_i | input | 7 | Unit bus address, 0 to 99 |
| evt_o | output | 8 | Sticky event register |
| tx_data_o | output | 8 | Message byte |
| tx_valid_o | output | 1 | Message byte valid |
| tx_ready_i | input | 1 | Consumer accepts byte |

## Verification
If an edge detector or mask bit is wrong, a wrong bit shows on `evt_o` one edge after the offending condition change. If the sequencer or pending flag is wrong, the stream shows a missing, extra or repeated byte. That appears within the message's four accepted bytes, or as a second `!` that should or should not appear right after the carriage return. Losing a held byte under backpressure shows as changed data or a dropped valid on the cycle after a refused handshake.

// File: rtl/srq_pkg.sv
package srq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BANG,
        ST_TENS,
        ST_ONES,
        ST_CR
    } srq_state_e;

    localparam logic [7:0] CH_BANG = 8'h21;
    localparam logic [7:0] CH_CR   = 8'h0D;
    localparam logic [7:0] CH_ZERO = 8'h30;
endpackage

// File: rtl/srq_edge_detect.sv
module srq_edge_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] cond_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] cond_q_o,
    output logic [W-1:0] rise_o,
    output logic         change_o
);
    logic [W-1:0] cond_q;

    // Previous-cycle copy; during power-up it tracks the live value, giving a baseline.
    always_ff @(posedge clk) begin
        cond_q <= cond_i;
    end

    assign cond_q_o = cond_q;
    assign rise_o   = cond_i & ~cond_q & mask_i;
    assign change_o = |((cond_i ^ cond_q) & mask_i);
endmodule

// File: rtl/srq_regs.sv
module srq_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         ena_wr_i,
    input  logic [W-1:0] ena_data_i,
    input  logic         mask_clr_i,
    input  logic         evt_clr_i,
    input  logic [W-1:0] evt_set_i,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] evt_o
);
    logic [W-1:0] mask_q;
    logic [W-1:0] evt_q;

    always_ff @(posedge clk) begin
        if (!por_n) begin
            mask_q <= '0;
        end else if (mask_clr_i) begin
            mask_q <= '0;
        end else if (ena_wr_i) begin
            mask_q <= ena_data_i;
        end
    end

    // Clear first, then OR in new edges: a same-cycle edge survives the clear.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= (evt_clr_i ? '0 : evt_q) | evt_set_i;
        end
    end

    assign mask_o = mask_q;
    assign evt_o  = evt_q;
endmodule

// File: rtl/srq_msg_tx.sv
module srq_msg_tx
    import srq_pkg::*;
#(
    parameter int AW       = 7,
    parameter int MAX_ADDR = 99
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          abort_i,
    input  logic          trig_i,
    input  logic [AW-1:0] addr_i,
    input  logic          ready_i,
    output logic          valid_o,
    output logic [7:0]    data_o
);
    localparam logic [AW-1:0] ADDR_CAP = AW'(MAX_ADDR);

    srq_state_e    state, state_nxt;
    logic          pend_q;
    logic [AW-1:0] addr_q;
    logic          go;
    logic          start;
    logic [7:0]    tens_chr;
    logic [7:0]    ones_chr;

    assign go    = trig_i | pend_q;
    assign start = go && ((state == ST_IDLE) || (state == ST_CR && ready_i));

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (go)      state_nxt = ST_BANG;
            ST_BANG: if (ready_i) state_nxt = ST_TENS;
            ST_TENS: if (ready_i) state_nxt = ST_ONES;
            ST_ONES: if (ready_i) state_nxt = ST_CR;
            ST_CR:   if (ready_i) state_nxt = go ? ST_BANG : ST_IDLE;
            default:              state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!por_n || abort_i) begin
            state  <= ST_IDLE;
            pend_q <= 1'b0;
            addr_q <= '0;
        end else begin
            state <= state_nxt;
            if (start) begin
                pend_q <= 1'b0;
                addr_q <= (addr_i > ADDR_CAP) ? ADDR_CAP : addr_i;
            end else if (state != ST_IDLE && trig_i) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign tens_chr = CH_ZERO + 8'(addr_q / AW'(10));
    assign ones_chr = CH_ZERO + 8'(addr_q % AW'(10));

    always_comb begin
        valid_o = 1'b1;
        data_o  = 8'h00;
        unique case (state)
            ST_IDLE: valid_o = 1'b0;
            ST_BANG: data_o  = CH_BANG;
            ST_TENS: data_o  = tens_chr;
            ST_ONES: data_o  = ones_chr;
            ST_CR:   data_o  = CH_CR;
            default: valid_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fault_srq_latch.sv
module fault_srq_latch #(
    parameter int COND_W   = 8,
    parameter int ADDR_W   = 7,
    parameter int MAX_ADDR = 99
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [COND_W-1:0] cond_i,
    input  logic              ena_wr_i,
    input  logic [COND_W-1:0] ena_data_i,
    input  logic              evt_rd_i,
    input  logic              cls_i,
    input  logic              rst_cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [COND_W-1:0] evt_o,
    output logic [7:0]        tx_data_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i
);
    logic [COND_W-1:0] ena_q;
    logic [COND_W-1:0] cond_q;
    logic [COND_W-1:0] rise;
    logic              change;

    srq_edge_detect #(.W(COND_W)) u_edge (
        .clk      (clk),
        .cond_i   (cond_i),
        .mask_i   (ena_q),
        .cond_q_o (cond_q),
        .rise_o   (rise),
        .change_o (change)
    );

    srq_regs #(.W(COND_W)) u_regs (
        .clk        (clk),
        .por_n      (por_n),
        .ena_wr_i   (ena_wr_i),
        .ena_data_i (ena_data_i),
        .mask_clr_i (rst_cmd_i),
        .evt_clr_i  (evt_rd_i | cls_i),
        .evt_set_i  (rise),
        .mask_o     (ena_q),
        .evt_o      (evt_o)
    );

    srq_msg_tx #(.AW(ADDR_W), .MAX_ADDR(MAX_ADDR)) u_tx (
        .clk     (clk),
        .por_n   (por_n),
        .abort_i (rst_cmd_i),
        .trig_i  (change),
        .addr_i  (addr_i),
        .ready_i (tx_ready_i),
        .valid_o (tx_valid_o),
        .data_o  (tx_data_o)
    );
endmodule

// File: rtl/srq_checker.sv
module srq_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         por_n,
    input logic         evt_rd_i,
    input logic         cls_i,
    input logic         rst_cmd_i,
    input logic [W-1:0] cond_i,
    input logic [W-1:0] cond_q,
    input logic [W-1:0] ena_q,
    input logic [W-1:0] evt_o,
    input logic         tx_valid_o,
    input logic         tx_ready_i,
    input logic [7:0]   tx_data_o
);
    a_r1_set_needs_enabled_rise: assert property (@(posedge clk) disable iff (!por_n)
        por_n |=> ((evt_o & ~$past(evt_o) & ~$past(ena_q & cond_i & ~cond_q)) == '0));

    a_r2_sticky_without_clear: assert property (@(posedge clk) disable iff (!por_n)
        (!evt_rd_i && !cls_i) |=> ((evt_o & $past(evt_o)) == $past(evt_o)));

    a_r5_reset_cmd_aborts: assert property (@(posedge clk) disable iff (!por_n)
        rst_cmd_i |=> !tx_valid_o);

    a_r6_powerup_clears: assert property (@(posedge clk)
        !por_n |=> (evt_o == '0 && !tx_valid_o));

    a_r8_message_leads_with_bang: assert property (@(posedge clk) disable iff (!por_n)
        $rose(tx_valid_o) |-> (tx_data_o == 8'h21));

    a_r9_hold_until_accepted: assert property (@(posedge clk) disable iff (!por_n)
        (tx_valid_o && !tx_ready_i && !rst_cmd_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

bind fault_srq_latch srq_checker #(.W(COND_W)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .evt_rd_i   (evt_rd_i),
    .cls_i      (cls_i),
    .rst_cmd_i  (rst_cmd_i),
    .cond_i     (cond_i),
    .cond_q     (cond_q),
    .ena_q      (ena_q),
    .evt_o      (evt_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .tx_data_o  (tx_data_o)
);

// File: tb/sim_fault_srq_latch.sv
module sim_fault_srq_latch;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;
    // {cond[8], mask data[8], flags {wr,rd,cls,rst}[4], expected evt[8]}
    localparam logic [27:0] VEC [NVEC] = '{
        28'h0012800, 28'h0200002, 28'h0000002, 28'h0400002, 28'h1400012,
        28'h1400400, 28'h1600402, 28'h1600200, 28'h1400100, 28'h1600000,
        28'h16FF800, 28'hFF000E9, 28'h00000E9, 28'h00001E9, 28'h0000200
    };

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [7:0] cond = '0;
    logic       ena_wr = 1'b0;
    logic [7:0] ena_data = '0;
    logic       evt_rd = 1'b0;
    logic       cls = 1'b0;
    logic       rst_cmd = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] evt;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_srq_latch u0 (
        .clk        (clk),
        .por_n      (por_n),
        .cond_i     (cond),
        .ena_wr_i   (ena_wr),
        .ena_data_i (ena_data),
        .evt_rd_i   (evt_rd),
        .cls_i      (cls),
        .rst_cmd_i  (rst_cmd),
        .addr_i     (addr),
        .evt_o      (evt),
        .tx_data_o  (tx_data),
        .tx_valid_o (tx_valid),
        .tx_ready_i (tx_ready)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic take(input logic [7:0] exp, input string what);
        for (int n = 0; n < 10 && !tx_valid; n++) step();
        chk(tx_valid && tx_data == exp, what, {23'd0, tx_valid, tx_data}, {24'd1, exp});
        step();
    endtask

    task automatic power_up();
        por_n = 1'b0;
        step();
        step();
        por_n = 1'b1;
    endtask

    task automatic write_mask(input logic [7:0] m);
        ena_wr = 1'b1;
        ena_data = m;
        step();
        ena_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        addr = 7'd3;
        power_up();
        step();
        chk(evt == 8'h00 && !tx_valid, "R6 reset state", {23'd0, tx_valid, evt}, 32'h0);

        // Table walk: R1/R2/R3/R4/R5 event register behaviour, ready held high
        for (int i = 0; i < NVEC; i++) begin
            cond     = VEC[i][27:20];
            ena_data = VEC[i][19:12];
            ena_wr   = VEC[i][11];
            evt_rd   = VEC[i][10];
            cls      = VEC[i][9];
            rst_cmd  = VEC[i][8];
            step();
            chk(evt == VEC[i][7:0], $sformatf("R1/R2/R3/R4/R5 table row %0d", i), {24'd0, evt}, {24'd0, VEC[i][7:0]});
        end
        ena_wr = 0; evt_rd = 0; cls = 0; rst_cmd = 0;

        // R8: rising change message with leading-zero address
        cond = '0;
        power_up();
        addr = 7'd7;
        write_mask(8'h02);
        cond = 8'h02;
        take(8'h21, "R8 bang");
        take(8'h30, "R8 tens digit 0");
        take(8'h37, "R8 ones digit 7");
        take(8'h0D, "R8 carriage return");
        chk(!tx_valid, "R8 idle after message", {31'd0, tx_valid}, 32'h0);

        // R9 backpressure, R8 falling change, R10 single follow-up message
        addr = 7'd42;
        tx_ready = 1'b0;
        cond = 8'h00;
        step();
        step();
        step();
        chk(tx_valid && tx_data == 8'h21, "R9 byte held under backpressure", {23'd0, tx_valid, tx_data}, 32'h121);
        cond = 8'h02;
        step();
        cond = 8'h00;
        step();
        tx_ready = 1'b1;
        take(8'h21, "R10 first bang");
        take(8'h34, "R10 first tens");
        take(8'h32, "R10 first ones");
        take(8'h0D, "R10 first cr");
        take(8'h21, "R10 second bang");
        take(8'h34, "R10 second tens");
        take(8'h32, "R10 second ones");
        take(8'h0D, "R10 second cr");
        step();
        step();
        chk(!tx_valid, "R10 no third message", {31'd0, tx_valid}, 32'h0);

        // R8 address clamp above 99
        addr = 7'd120;
        cond = 8'h02;
        take(8'h21, "R8 clamp bang");
        take(8'h39, "R8 clamp tens 9");
        take(8'h39, "R8 clamp ones 9");
        take(8'h0D, "R8 clamp cr");

        // R7: mask 0x00 silences changes; event register untouched (holds 0x02)
        write_mask(8'h00);
        cond = 8'h00;
        step();
        cond = 8'h02;
        step();
        step();
        chk(!tx_valid && evt == 8'h02, "R7 zero mask no message or event", {23'd0, tx_valid, evt}, 32'h02);

        // R6: conditions present at power-up release are a baseline
        cond = 8'hFF;
        power_up();
        write_mask(8'hFF);
        step();
        step();
        chk(!tx_valid && evt == 8'h00, "R6 baseline no event or message", {23'd0, tx_valid, evt}, 32'h0);

        // R5: reset command aborts message, keeps events, clears mask
        cond = 8'hFE;
        step();
        step();
        chk(tx_valid, "R5 message under way", {31'd0, tx_valid}, 32'h1);
        rst_cmd = 1'b1;
        step();
        rst_cmd = 1'b0;
        chk(!tx_valid && evt == 8'h00, "R5 abort, event kept (falling edge only)", {23'd0, tx_valid, evt}, 32'h0);
        cond = 8'hFF;
        step();
        step();
        chk(!tx_valid && evt == 8'h00, "R5 mask cleared by reset command", {23'd0, tx_valid, evt}, 32'h0);
        write_mask(8'h01);
        cond = 8'hFE;
        step();
        cond = 8'hFF;
        step();
        rst_cmd = 1'b1;
        step();
        rst_cmd = 1'b0;
        chk(evt == 8'h01, "R5 event survives reset command", {24'd0, evt}, 32'h01);

        // R3: same-cycle read and new edge, checked with a different bit
        write_mask(8'h81);
        cond = 8'h7F;
        step();
        cond = 8'hFF;
        evt_rd = 1'b1;
        step();
        evt_rd = 1'b0;
        chk(evt == 8'h80, "R3 new edge wins over read clear", {24'd0, evt}, 32'h80);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule